// File: doc/BRIEF.md
# Paged Program Address Sequencer

This block produces the instruction fetch address for a 4096-word program store. The store is organised as four banks, each of sixteen pages, each page holding 64 words. The block keeps four pieces of state:

- a 6-bit word counter;
- a 6-bit page/bank selector;
- a 6-bit staging buffer for the next page;
- a three-deep return stack that saves word and page together.

An external instruction decoder drives one strobe per executed instruction. The strobes are ordinary step, buffer load, jump, call and return. The decoder also supplies the condition flag that gates jumps and calls.

Because an instruction cannot carry both a page and a word, a far transfer takes two stages. The target page is first staged in the buffer by one or two consecutive buffer loads: the page nibble first, then the two bank bits. A taken jump or call then commits the buffer to the page selector, while the word operand goes to the counter. Ordinary fetches never touch the page, so straight-line code wraps inside its page.

Top module: `prog_addr_seq`

## Requirements
- R1: `fetch_addr[5:0]` is the word counter, `fetch_addr[9:6]` is the page and `fetch_addr[11:10]` is the bank of the page selector.
- R2: While `rst_n` is low, the word counter, page selector, staging buffer and return stack are all zero, and `stack_ovf` is 0.
- R3: A step (`step_en`) adds one to the word counter modulo 64 (63 wraps to 0) and leaves the page selector unchanged.
- R4: A buffer load (`pbuf_ld`) that does not directly follow another buffer load writes `pbuf_imm[3:0]` into buffer bits [3:0]. A buffer load directly following one writes `pbuf_imm[1:0]` into buffer bits [5:4] and keeps bits [3:0]. A buffer load advances the word counter and does not change the page selector.
- R5: Any instruction other than a buffer load (step, jump, call, return, taken or not) ends the consecutive-load chain, so the next buffer load writes bits [3:0] again. Cycles with no strobe do not end the chain.
- R6: A jump (`jmp_en`) with `cond_in`=1 loads `word_opd` into the word counter and the staging buffer into the page selector.
- R7: A jump or call with `cond_in`=0 only advances the word counter and keeps the page. `st_force` is 1 during that cycle so that the decoder sets its flag to 1.
- R8: A call with `cond_in`=1 jumps as in R6 and pushes {page selector, word counter + 1} onto the stack. A return (`ret_en`) reloads both page and word from the newest entry, so nested calls return in last-in first-out order across pages.
- R9: A call while three entries are held discards the oldest entry and sets `stack_ovf`. The flag then stays 1 until reset.
- R10: A return with an empty stack loads word 0 of page 0, bank 0.
- R11: When several strobes are high in one cycle, return beats call, call beats jump, jump beats buffer load, and buffer load beats step. With no strobe the address holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Ordinary instruction: advance word |
| pbuf_ld | input | 1 | Load staging buffer from immediate |
| pbuf_imm | input | 4 | Buffer load immediate |
| jmp_en | input | 1 | Conditional jump |
| call_en | input | 1 | Conditional call |
| ret_en | input | 1 | Return from subroutine |
| word_opd | input | 6 | Word operand of jump/call |
| cond_in | input | 1 | Condition flag gating jump/call |
| fetch_addr | output | 12 | {bank, page, word} fetch address |
| st_force | output | 1 | Untaken jump/call: force flag to 1 |
| stack_ovf | output | 1 | Sticky return stack overflow |

## Verification
On every cycle, the assertions check the following:

- a plain step or untaken transfer keeps the page and adds one to the word;
- a taken jump lands on its operand;
- a buffer load never moves the page;
- an idle cycle holds the address;
- the overflow flag never falls outside reset.

Behaviours that need history spanning several instructions can only be shown by the bench's scenarios. These are the two-stage page/bank staging and its chain break, cross-page return order, the discarding of the oldest entry on overflow, and the return from an empty stack.

// File: rtl/pas_pkg.sv
package pas_pkg;

  // Resolved action of one cycle, after strobe priority and condition.
  typedef enum logic [2:0] {
    ACT_HOLD = 3'd0,
    ACT_STEP = 3'd1,
    ACT_PBUF = 3'd2,
    ACT_JUMP = 3'd3,
    ACT_CALL = 3'd4,
    ACT_RET  = 3'd5
  } act_e;

  localparam int DEF_WORD_W = 6;
  localparam int DEF_PAGE_W = 4;
  localparam int DEF_BANK_W = 2;
  localparam int DEF_DEPTH  = 3;

endpackage

// File: rtl/pas_decode.sv
module pas_decode
  import pas_pkg::*;
(
  input  logic step_en,
  input  logic pbuf_ld,
  input  logic jmp_en,
  input  logic call_en,
  input  logic ret_en,
  input  logic cond_in,
  output act_e act,
  output logic st_force
);

  // Priority: return > call > jump > buffer load > step.
  always_comb begin
    act      = ACT_HOLD;
    st_force = 1'b0;
    if (ret_en) begin
      act = ACT_RET;
    end else if (call_en) begin
      if (cond_in) begin
        act = ACT_CALL;
      end else begin
        act      = ACT_STEP;
        st_force = 1'b1;
      end
    end else if (jmp_en) begin
      if (cond_in) begin
        act = ACT_JUMP;
      end else begin
        act      = ACT_STEP;
        st_force = 1'b1;
      end
    end else if (pbuf_ld) begin
      act = ACT_PBUF;
    end else if (step_en) begin
      act = ACT_STEP;
    end
  end

endmodule

// File: rtl/pas_page_buffer.sv
module pas_page_buffer
  import pas_pkg::*;
#(
  parameter int LO_W = DEF_PAGE_W,
  parameter int HI_W = DEF_BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  act_e                 act,
  input  logic [LO_W-1:0]      imm,
  output logic [LO_W+HI_W-1:0] pbuf
);

  localparam int BUF_W = LO_W + HI_W;

  logic [BUF_W-1:0] buf_q, buf_d;
  logic             chain_q, chain_d;
  logic             buf_en;

  always_comb begin
    buf_d   = buf_q;
    chain_d = chain_q;
    buf_en  = 1'b0;
    if (act == ACT_PBUF) begin
      buf_en  = 1'b1;
      chain_d = 1'b1;
      if (chain_q) begin
        buf_d[BUF_W-1:LO_W] = imm[HI_W-1:0];
      end else begin
        buf_d[LO_W-1:0] = imm;
      end
    end else if (act != ACT_HOLD) begin
      chain_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (buf_en) begin
      buf_q <= buf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= 1'b0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign pbuf = buf_q;

endmodule

// File: rtl/pas_addr_reg.sv
module pas_addr_reg
  import pas_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int SEL_W  = DEF_PAGE_W + DEF_BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  act_e              act,
  input  logic [WORD_W-1:0] opd,
  input  logic [SEL_W-1:0]  pbuf,
  input  logic [WORD_W-1:0] ret_word,
  input  logic [SEL_W-1:0]  ret_sel,
  output logic [WORD_W-1:0] word,
  output logic [SEL_W-1:0]  sel,
  output logic [WORD_W-1:0] link_word
);

  logic [WORD_W-1:0] word_q, word_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic              word_en, sel_en;
  logic [WORD_W-1:0] word_inc;

  assign word_inc = word_q + {{(WORD_W-1){1'b0}}, 1'b1};

  always_comb begin
    word_d  = word_q;
    sel_d   = sel_q;
    word_en = 1'b0;
    sel_en  = 1'b0;
    unique case (act)
      ACT_STEP, ACT_PBUF: begin
        word_d  = word_inc;
        word_en = 1'b1;
      end
      ACT_JUMP, ACT_CALL: begin
        word_d  = opd;
        sel_d   = pbuf;
        word_en = 1'b1;
        sel_en  = 1'b1;
      end
      ACT_RET: begin
        word_d  = ret_word;
        sel_d   = ret_sel;
        word_en = 1'b1;
        sel_en  = 1'b1;
      end
      default: begin
        word_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  assign word      = word_q;
  assign sel       = sel_q;
  assign link_word = word_inc;

endmodule

// File: rtl/pas_return_stack.sv
module pas_return_stack
  import pas_pkg::*;
#(
  parameter int DEPTH = DEF_DEPTH,
  parameter int ENT_W = DEF_WORD_W + DEF_PAGE_W + DEF_BANK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  act_e             act,
  input  logic [ENT_W-1:0] push_data,
  output logic [ENT_W-1:0] top_data,
  output logic             ovf
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [ENT_W-1:0] ent_q [DEPTH];
  logic [ENT_W-1:0] ent_d [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             push, pop, stk_en;

  assign push   = (act == ACT_CALL);
  assign pop    = (act == ACT_RET);
  assign stk_en = push | pop;

  // Level 0 is the newest entry; vacated slots fill with zero.
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
      if (i == 0) begin : g_top
        always_comb begin
          ent_d[i] = ent_q[i];
          if (push) begin
            ent_d[i] = push_data;
          end else if (pop) begin
            ent_d[i] = (DEPTH > 1) ? ent_q[(DEPTH > 1) ? 1 : 0] : '0;
          end
        end
      end else if (i == DEPTH - 1) begin : g_bot
        always_comb begin
          ent_d[i] = ent_q[i];
          if (push) begin
            ent_d[i] = ent_q[i-1];
          end else if (pop) begin
            ent_d[i] = '0;
          end
        end
      end else begin : g_mid
        always_comb begin
          ent_d[i] = ent_q[i];
          if (push) begin
            ent_d[i] = ent_q[i-1];
          end else if (pop) begin
            ent_d[i] = ent_q[i+1];
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ent_q[i] <= '0;
        end else if (stk_en) begin
          ent_q[i] <= ent_d[i];
        end
      end
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (push) begin
      if (cnt_q == FULL) begin
        ovf_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (pop) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (stk_en) begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign top_data = ent_q[0];
  assign ovf      = ovf_q;

endmodule

// File: rtl/prog_addr_seq.sv
module prog_addr_seq
  import pas_pkg::*;
#(
  parameter int WORD_W      = DEF_WORD_W,
  parameter int PAGE_W      = DEF_PAGE_W,
  parameter int BANK_W      = DEF_BANK_W,
  parameter int STACK_DEPTH = DEF_DEPTH
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             step_en,
  input  logic                             pbuf_ld,
  input  logic [PAGE_W-1:0]                pbuf_imm,
  input  logic                             jmp_en,
  input  logic                             call_en,
  input  logic                             ret_en,
  input  logic [WORD_W-1:0]                word_opd,
  input  logic                             cond_in,
  output logic [WORD_W+PAGE_W+BANK_W-1:0]  fetch_addr,
  output logic                             st_force,
  output logic                             stack_ovf
);

  localparam int SEL_W  = PAGE_W + BANK_W;
  localparam int ADDR_W = WORD_W + SEL_W;

  act_e              act;
  logic [SEL_W-1:0]  pbuf;
  logic [WORD_W-1:0] word, link_word, ret_word;
  logic [SEL_W-1:0]  sel, ret_sel;
  logic [ADDR_W-1:0] top_ent;

  pas_decode u_dec (
    .step_en  (step_en),
    .pbuf_ld  (pbuf_ld),
    .jmp_en   (jmp_en),
    .call_en  (call_en),
    .ret_en   (ret_en),
    .cond_in  (cond_in),
    .act      (act),
    .st_force (st_force)
  );

  pas_page_buffer #(.LO_W(PAGE_W), .HI_W(BANK_W)) u_pbuf (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .imm   (pbuf_imm),
    .pbuf  (pbuf)
  );

  pas_addr_reg #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_areg (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (act),
    .opd       (word_opd),
    .pbuf      (pbuf),
    .ret_word  (ret_word),
    .ret_sel   (ret_sel),
    .word      (word),
    .sel       (sel),
    .link_word (link_word)
  );

  pas_return_stack #(.DEPTH(STACK_DEPTH), .ENT_W(ADDR_W)) u_stk (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (act),
    .push_data ({sel, link_word}),
    .top_data  (top_ent),
    .ovf       (stack_ovf)
  );

  assign ret_word   = top_ent[WORD_W-1:0];
  assign ret_sel    = top_ent[ADDR_W-1:WORD_W];
  assign fetch_addr = {sel, word};

endmodule

// File: rtl/pas_checker.sv
module pas_checker #(
  parameter int WORD_W = 6,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_en,
  input logic              pbuf_ld,
  input logic              jmp_en,
  input logic              call_en,
  input logic              ret_en,
  input logic              cond_in,
  input logic [WORD_W-1:0] word_opd,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              stack_ovf
);

  logic only_step, only_pbuf, jmp_taken, jmp_skip, none;

  assign only_step = step_en & ~pbuf_ld & ~jmp_en & ~call_en & ~ret_en;
  assign only_pbuf = pbuf_ld & ~jmp_en & ~call_en & ~ret_en;
  assign jmp_taken = jmp_en & cond_in & ~call_en & ~ret_en;
  assign jmp_skip  = jmp_en & ~cond_in & ~call_en & ~ret_en;
  assign none      = ~step_en & ~pbuf_ld & ~jmp_en & ~call_en & ~ret_en;

  // R3
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    only_step |=> ($stable(fetch_addr[ADDR_W-1:WORD_W]) &&
                   fetch_addr[WORD_W-1:0] == WORD_W'($past(fetch_addr[WORD_W-1:0]) + 1'b1)));

  // R4
  pbuf_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    only_pbuf |=> $stable(fetch_addr[ADDR_W-1:WORD_W]));

  // R6
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_taken |=> fetch_addr[WORD_W-1:0] == $past(word_opd));

  // R7
  untaken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_skip |=> ($stable(fetch_addr[ADDR_W-1:WORD_W]) &&
                  fetch_addr[WORD_W-1:0] == WORD_W'($past(fetch_addr[WORD_W-1:0]) + 1'b1)));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_ovf |=> stack_ovf);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    none |=> $stable(fetch_addr));

endmodule

bind prog_addr_seq pas_checker #(.WORD_W(WORD_W), .ADDR_W(WORD_W + PAGE_W + BANK_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_en    (step_en),
  .pbuf_ld    (pbuf_ld),
  .jmp_en     (jmp_en),
  .call_en    (call_en),
  .ret_en     (ret_en),
  .cond_in    (cond_in),
  .word_opd   (word_opd),
  .fetch_addr (fetch_addr),
  .stack_ovf  (stack_ovf)
);

// File: tb/prog_addr_seq_tb_top.sv
module prog_addr_seq_tb_top;

  logic        clk;
  logic        rst_n;
  logic        step_en, pbuf_ld, jmp_en, call_en, ret_en, cond_in;
  logic [3:0]  pbuf_imm;
  logic [5:0]  word_opd;
  logic [11:0] fetch_addr;
  logic        st_force, stack_ovf;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  prog_addr_seq dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .pbuf_ld    (pbuf_ld),
    .pbuf_imm   (pbuf_imm),
    .jmp_en     (jmp_en),
    .call_en    (call_en),
    .ret_en     (ret_en),
    .word_opd   (word_opd),
    .cond_in    (cond_in),
    .fetch_addr (fetch_addr),
    .st_force   (st_force),
    .stack_ovf  (stack_ovf)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Ops: 0 idle, 1 step, 2 buffer load, 3 jump, 4 call, 5 return.
  // Entry: {op[2:0], arg[5:0], cond, expected fetch_addr[11:0]}.
  localparam int NV = 13;
  localparam logic [21:0] VEC [NV] = '{
    {3'd1, 6'h00, 1'b0, 12'h001},  // R3 step
    {3'd2, 6'h07, 1'b0, 12'h002},  // R4 first load -> low nibble
    {3'd2, 6'h03, 1'b0, 12'h003},  // R4 second load -> bank bits
    {3'd3, 6'h2A, 1'b1, 12'hDEA},  // R6 R1 taken jump commits 11_0111
    {3'd1, 6'h00, 1'b0, 12'hDEB},  // R3
    {3'd2, 6'h05, 1'b0, 12'hDEC},  // R5 chain broken -> low nibble
    {3'd1, 6'h00, 1'b0, 12'hDED},  // R5 step breaks chain
    {3'd2, 6'h02, 1'b0, 12'hDEE},  // R5 low nibble again: buffer 11_0010
    {3'd4, 6'h10, 1'b1, 12'hC90},  // R8 call pushes (2F, 11_0111)
    {3'd1, 6'h00, 1'b0, 12'hC91},  // R3
    {3'd3, 6'h05, 1'b0, 12'hC92},  // R7 untaken jump
    {3'd5, 6'h00, 1'b0, 12'hDEF},  // R8 return restores page
    {3'd1, 6'h00, 1'b0, 12'hDF0}   // R3
  };

  task automatic clear_in();
    step_en = 0; pbuf_ld = 0; jmp_en = 0; call_en = 0; ret_en = 0;
    cond_in = 0; pbuf_imm = '0; word_opd = '0;
  endtask

  task automatic drive(input logic [2:0] op, input logic [5:0] arg, input logic st);
    clear_in();
    step_en  = (op == 3'd1);
    pbuf_ld  = (op == 3'd2);
    jmp_en   = (op == 3'd3);
    call_en  = (op == 3'd4);
    ret_en   = (op == 3'd5);
    pbuf_imm = arg[3:0];
    word_opd = arg;
    cond_in  = st;
  endtask

  // Called at a negedge with inputs set: one rising edge, back at negedge.
  task automatic tick();
    @(negedge clk);
    clear_in();
  endtask

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    clear_in();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    clear_in();
    rst_n = 1'b0;
    @(negedge clk);
    check("R2 addr in reset", fetch_addr, 12'h000);
    check("R2 ovf in reset", {11'd0, stack_ovf}, 12'h000);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][21:19], VEC[i][18:13], VEC[i][12]);
      tick();
      check($sformatf("vector %0d", i), fetch_addr, VEC[i][11:0]);
    end

    // R3 wrap 0x3F -> 0 inside page 11_0111
    for (int i = 0; i < 16; i++) begin
      drive(3'd1, 6'h00, 1'b0);
      tick();
    end
    check("R3 wrap in page", fetch_addr, 12'hDC0);

    // R11 idle holds
    repeat (3) @(negedge clk);
    check("R11 idle hold", fetch_addr, 12'hDC0);

    // R7 st_force during untaken call, word advances
    drive(3'd4, 6'h11, 1'b0);
    #1;
    check("R7 st_force untaken", {11'd0, st_force}, 12'h001);
    tick();
    check("R7 untaken call", fetch_addr, 12'hDC1);
    drive(3'd3, 6'h11, 1'b1);
    #1;
    check("R7 st_force clear when taken", {11'd0, st_force}, 12'h000);
    tick();

    // R8 R9 R10 stack depth, overflow and empty return
    do_reset();
    drive(3'd2, 6'h01, 1'b0); tick();
    drive(3'd4, 6'h08, 1'b1); tick();
    drive(3'd2, 6'h02, 1'b0); tick();
    drive(3'd4, 6'h10, 1'b1); tick();
    drive(3'd2, 6'h03, 1'b0); tick();
    drive(3'd4, 6'h20, 1'b1); tick();
    check("R9 no ovf at three", {11'd0, stack_ovf}, 12'h000);
    drive(3'd2, 6'h04, 1'b0); tick();
    drive(3'd4, 6'h30, 1'b1); tick();
    check("R8 fourth call", fetch_addr, 12'h130);
    check("R9 ovf set", {11'd0, stack_ovf}, 12'h001);
    drive(3'd5, 6'h00, 1'b0); tick();
    check("R8 return 1", fetch_addr, 12'h0E2);
    drive(3'd5, 6'h00, 1'b0); tick();
    check("R8 return 2", fetch_addr, 12'h092);
    drive(3'd5, 6'h00, 1'b0); tick();
    check("R9 oldest discarded, return 3", fetch_addr, 12'h04A);
    drive(3'd5, 6'h00, 1'b0); tick();
    check("R10 empty return", fetch_addr, 12'h000);
    check("R9 ovf sticky", {11'd0, stack_ovf}, 12'h001);
    do_reset();
    check("R2 ovf cleared", {11'd0, stack_ovf}, 12'h000);

    // R11 priority
    drive(3'd3, 6'h15, 1'b1); step_en = 1'b1; tick();
    check("R11 jump over step", fetch_addr, 12'h015);
    drive(3'd5, 6'h22, 1'b1); call_en = 1'b1; tick();
    check("R11 return over call", fetch_addr, 12'h000);
    drive(3'd2, 6'h05, 1'b0); step_en = 1'b1; tick();
    check("R11 load over step", fetch_addr, 12'h001);
    drive(3'd3, 6'h03, 1'b1); tick();
    check("R11 R4 loaded page used", fetch_addr, 12'h143);

    // R5 idle cycle keeps chain: load 2, idle, load 1 -> bank 01
    drive(3'd2, 6'h02, 1'b0); tick();
    @(negedge clk);
    drive(3'd2, 6'h01, 1'b0); tick();
    drive(3'd3, 6'h00, 1'b1); tick();
    check("R5 idle keeps chain", fetch_addr, 12'h480);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule